// File: doc/BRIEF.md
# Dual Maskable Calendar Alarm

This block watches a running clock/calendar and raises an alarm when the current time agrees with a programmed pattern. It holds two independent alarm slots. Each slot stores a reference value for six time fields (second, minute, hour, day of month, month, weekday), and each field has its own enable bit. Only enabled fields take part in the comparison. This lets one slot express a one-off instant, a repeating pattern such as "every minute at second 30", or a weekday combined with a date.

The comparison is made only on the cycle where the one-second tick is high. A successful match latches a sticky per-slot status flag, which software polls and clears with a clear strobe. An active-low interrupt line is pulled low while any flag whose interrupt enable is set is high. The timekeeping counter is outside this block; it supplies the current fields and the tick.

All pins are plain control and status signals. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure to handle. A configuration write is a single-cycle strobe that is always accepted.

Top module: `cal_alarm_top`

## Requirements
- R1: After reset both flags read 0, `irq_n` is 1, and every field enable of both slots is 0.
- R2: When `cfg_we` is high at a clock edge, the slot selected by `cfg_sel` takes `cfg_value` and `cfg_enable` into field `cfg_field`. Field indices are 0 second, 1 minute, 2 hour, 3 day, 4 month, 5 weekday. `now_time[8*i +: 8]` carries field i. The write affects every tick sampled at a later edge.
- R3: A slot is compared only on edges where `tick` is high. A matching `now_time` without `tick` leaves the flags unchanged.
- R4: A field whose enable is 0 is left out of the comparison, so a mismatch in that field does not stop a match.
- R5: A slot with all six enables at 0 never sets its flag.
- R6: The two slots are independent. Each matches on its own fields and sets only its own flag bit (bit 0 for slot 0, bit 1 for slot 1).
- R7: A set flag stays at 1 through later non-matching ticks until `flag_clr` has its bit high at an edge. It reads 0 after that edge.
- R8: If a flag's clear bit and a match on a tick occur at the same edge, the flag is 1 after that edge.
- R9: `irq_n` is 0 exactly when some flag is 1 and its bit in the interrupt enable register is 1. It follows the flags with no further delay. The enable register is loaded from `ien_val` when `ien_we` is high and resets to 0.
- R10: The comparison is an equality test on the raw 8-bit codes, with no BCD normalisation. For example, a reference of 8'h3A matches only 8'h3A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-second strobe; compare enable |
| now_time | input | 48 | Current time, six 8-bit BCD fields |
| cfg_we | input | 1 | Field write strobe |
| cfg_sel | input | 1 | Slot select for the write |
| cfg_field | input | 3 | Field index for the write |
| cfg_value | input | 8 | Reference value to store |
| cfg_enable | input | 1 | Enable bit to store with the field |
| ien_we | input | 1 | Interrupt enable write strobe |
| ien_val | input | 2 | Per-slot interrupt enable bits |
| flag_clr | input | 2 | Per-slot flag clear strobe |
| alarm_flag | output | 2 | Sticky per-slot alarm flags |
| irq_n | output | 1 | Active-low interrupt |

## Verification
A tick presented before an edge shows up in `alarm_flag` right after that edge. `irq_n` changes in the same cycle as the flags, because it is combinational from them. Configuration and clear strobes take effect at the next edge.

The bench changes every input just after a falling edge and reads the results at the following falling edge. That is half a cycle after the one edge that updates them, so the read never races the update. The main sweep steps the calendar through two hours, one tick per second. For each tick, the expected flags are worked out arithmetically from the second, minute and hour counts, and then the flags are cleared so every second is judged on its own.

// File: rtl/cal_alarm_pkg.sv
package cal_alarm_pkg;
  // Default geometry of the alarm block.
  localparam int unsigned CA_FIELDS = 6;  // second, minute, hour, day, month, weekday
  localparam int unsigned CA_FW     = 8;  // one BCD byte per field
  localparam int unsigned CA_SLOTS  = 2;  // independent alarm slots

  // Field index encoding used by the configuration port.
  typedef enum logic [2:0] {
    FLD_SEC   = 3'd0,
    FLD_MIN   = 3'd1,
    FLD_HOUR  = 3'd2,
    FLD_DAY   = 3'd3,
    FLD_MONTH = 3'd4,
    FLD_WDAY  = 3'd5
  } cal_field_e;
endpackage

// File: rtl/cal_alarm_slot.sv
// One alarm slot: per-field reference registers, per-field enables and the
// masked equality compare against the running time.
module cal_alarm_slot #(
  parameter int unsigned NF     = 6,
  parameter int unsigned FW     = 8,
  parameter int unsigned FIDX_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [FIDX_W-1:0] wr_field,
  input  logic [FW-1:0]     wr_value,
  input  logic              wr_enable,
  input  logic [NF*FW-1:0]  now_time,
  output logic              hit,
  output logic              armed
);
  logic [NF-1:0] en_vec;
  logic [NF-1:0] field_ok;

  for (genvar f = 0; f < NF; f++) begin : g_field
    logic [FW-1:0] ref_q;
    logic          en_q;
    logic          sel;

    assign sel = wr_en && (wr_field == FIDX_W'(f));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ref_q <= '0;
        en_q  <= 1'b0;
      end else if (sel) begin
        ref_q <= wr_value;
        en_q  <= wr_enable;
      end
    end

    assign en_vec[f]   = en_q;
    // A disabled field always agrees; an enabled one needs exact code equality.
    assign field_ok[f] = !en_q || (ref_q == now_time[f*FW +: FW]);
  end

  assign armed = |en_vec;
  assign hit   = armed && (&field_ok);
endmodule

// File: rtl/cal_alarm_flag.sv
// Sticky alarm flag: set wins over clear when both arrive together.
module cal_alarm_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag <= 1'b0;
    else if (set) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end
endmodule

// File: rtl/cal_alarm_irq.sv
// Interrupt enable register and active-low interrupt gating.
module cal_alarm_irq #(
  parameter int unsigned NA = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ien_we,
  input  logic [NA-1:0] ien_val,
  input  logic [NA-1:0] flags,
  output logic          irq_n
);
  logic [NA-1:0] ien_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ien_q <= '0;
    else if (ien_we) ien_q <= ien_val;
  end

  assign irq_n = ~|(flags & ien_q);
endmodule

// File: rtl/cal_alarm_top.sv
module cal_alarm_top
  import cal_alarm_pkg::*;
#(
  parameter int unsigned NF = CA_FIELDS,
  parameter int unsigned FW = CA_FW,
  parameter int unsigned NA = CA_SLOTS,
  localparam int unsigned SEL_W  = (NA > 1) ? $clog2(NA) : 1,
  localparam int unsigned FIDX_W = (NF > 1) ? $clog2(NF) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [NF*FW-1:0]  now_time,
  input  logic              cfg_we,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic [FIDX_W-1:0] cfg_field,
  input  logic [FW-1:0]     cfg_value,
  input  logic              cfg_enable,
  input  logic              ien_we,
  input  logic [NA-1:0]     ien_val,
  input  logic [NA-1:0]     flag_clr,
  output logic [NA-1:0]     alarm_flag,
  output logic              irq_n
);
  logic [NA-1:0] slot_hit;
  logic [NA-1:0] slot_armed;

  for (genvar a = 0; a < NA; a++) begin : g_slot
    logic slot_we;
    assign slot_we = cfg_we && (cfg_sel == SEL_W'(a));

    cal_alarm_slot #(.NF(NF), .FW(FW), .FIDX_W(FIDX_W)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (slot_we),
      .wr_field  (cfg_field),
      .wr_value  (cfg_value),
      .wr_enable (cfg_enable),
      .now_time  (now_time),
      .hit       (slot_hit[a]),
      .armed     (slot_armed[a])
    );

    cal_alarm_flag u_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (tick && slot_hit[a]),
      .clr   (flag_clr[a]),
      .flag  (alarm_flag[a])
    );
  end

  cal_alarm_irq #(.NA(NA)) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .ien_we  (ien_we),
    .ien_val (ien_val),
    .flags   (alarm_flag),
    .irq_n   (irq_n)
  );
endmodule

// File: rtl/cal_alarm_chk.sv
module cal_alarm_chk #(
  parameter int unsigned NA = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic [NA-1:0] flag_clr,
  input logic [NA-1:0] alarm_flag,
  input logic          irq_n,
  input logic [NA-1:0] slot_armed
);
  for (genvar k = 0; k < NA; k++) begin : g_chk
    // R3
    no_tick_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> !$rose(alarm_flag[k]));

    // R5
    unarmed_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !slot_armed[k]) |=> !$rose(alarm_flag[k]));

    // R7
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (alarm_flag[k] && !flag_clr[k]) |=> alarm_flag[k]);

    // R7
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_clr[k] && !tick) |=> !alarm_flag[k]);
  end

  // R9
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> (|alarm_flag));
endmodule

bind cal_alarm_top cal_alarm_chk #(.NA(NA)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick       (tick),
  .flag_clr   (flag_clr),
  .alarm_flag (alarm_flag),
  .irq_n      (irq_n),
  .slot_armed (slot_armed)
);

// File: tb/test_cal_alarm_top.sv
`timescale 1ns/1ps
module test_cal_alarm_top;
  localparam int NF = 6;
  localparam int FW = 8;
  localparam int NA = 2;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            tick = 1'b0;
  logic [NF*FW-1:0] now_time = '0;
  logic            cfg_we = 1'b0;
  logic [0:0]      cfg_sel = '0;
  logic [2:0]      cfg_field = '0;
  logic [FW-1:0]   cfg_value = '0;
  logic            cfg_enable = 1'b0;
  logic            ien_we = 1'b0;
  logic [NA-1:0]   ien_val = '0;
  logic [NA-1:0]   flag_clr = '0;
  logic [NA-1:0]   alarm_flag;
  logic            irq_n;

  int vectors = 0;
  int miscompares = 0;

  always #10 clk = ~clk;

  cal_alarm_top i_cal_alarm_top (
    .clk, .rst_n, .tick, .now_time, .cfg_we, .cfg_sel, .cfg_field,
    .cfg_value, .cfg_enable, .ien_we, .ien_val, .flag_clr, .alarm_flag, .irq_n
  );

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] bcd(input int n);
    return 8'(((n / 10) << 4) | (n % 10));
  endfunction

  // Build the six fields: sec, min, hour, day, month, weekday.
  function automatic logic [NF*FW-1:0] pack(input logic [7:0] s, input logic [7:0] m,
                                            input logic [7:0] h, input logic [7:0] d,
                                            input logic [7:0] mo, input logic [7:0] w);
    return {w, mo, d, h, m, s};
  endfunction

  task automatic wr(input int slot, input int fld, input logic [7:0] val, input logic en);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 1'(slot); cfg_field = 3'(fld);
    cfg_value = val; cfg_enable = en;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_ien(input logic [NA-1:0] v);
    @(negedge clk);
    ien_we = 1'b1; ien_val = v;
    @(negedge clk);
    ien_we = 1'b0;
  endtask

  // Tick once with the given time (and optional clear); results readable on return.
  task automatic tick_at(input logic [NF*FW-1:0] t, input logic [NA-1:0] clr);
    @(negedge clk);
    now_time = t; tick = 1'b1; flag_clr = clr;
    @(negedge clk);
    tick = 1'b0; flag_clr = '0;
  endtask

  task automatic clear_all();
    @(negedge clk);
    flag_clr = '1;
    @(negedge clk);
    flag_clr = '0;
  endtask

  initial begin
    #(20 * 200000);
    miscompares++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [NF*FW-1:0] m30;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 flags", int'(alarm_flag), 0);
    check("R1 irq_n", int'(irq_n), 1);
    rst_n = 1'b1;
    // R1/R5: all enables zero after reset, so nothing fires even on a tick
    tick_at(pack(8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00), '0);
    check("R1 R5 unarmed after reset", int'(alarm_flag), 0);

    // Slot 0: second == 30 only. Slot 1: minute == 15 and weekday == 1.
    wr(0, 0, 8'h30, 1'b1);
    wr(1, 1, 8'h15, 1'b1);
    wr(1, 5, 8'h01, 1'b1);
    set_ien(2'b01);

    // R2 R4 R6 R9: two-hour sweep, one tick per second
    for (int t = 0; t < 7200; t++) begin
      int e0, e1;
      e0 = ((t % 60) == 30) ? 1 : 0;
      e1 = (((t / 60) % 60) == 15 && (t / 3600) == 1) ? 1 : 0;
      tick_at(pack(bcd(t % 60), bcd((t / 60) % 60), bcd(t / 3600),
                   8'h21, 8'h03, 8'((t / 3600) % 7)), '0);
      check("R4 R6 slot0", int'(alarm_flag[0]), e0);
      check("R4 R6 slot1", int'(alarm_flag[1]), e1);
      check("R9 irq_n sweep", int'(irq_n), e0 ? 0 : 1);
      clear_all();
    end

    m30 = pack(8'h30, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);

    // R3: matching time held without tick
    @(negedge clk);
    now_time = m30;
    repeat (3) @(negedge clk);
    check("R3 no tick", int'(alarm_flag[0]), 0);

    // R7: sticky across non-matching ticks, then cleared
    tick_at(m30, '0);
    check("R7 set", int'(alarm_flag[0]), 1);
    tick_at(pack(8'h31, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00), '0);
    tick_at(pack(8'h45, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00), '0);
    check("R7 sticky", int'(alarm_flag[0]), 1);
    clear_all();
    check("R7 cleared", int'(alarm_flag[0]), 0);

    // R8: clear and match on the same edge
    tick_at(m30, 2'b01);
    check("R8 set beats clear", int'(alarm_flag[0]), 1);

    // R9: interrupt gating by enable register
    set_ien(2'b10);
    check("R9 masked flag", int'(irq_n), 1);
    set_ien(2'b11);
    check("R9 unmasked flag", int'(irq_n), 0);
    clear_all();
    check("R9 released", int'(irq_n), 1);

    // R10: raw code equality
    wr(0, 0, 8'h3A, 1'b1);
    tick_at(pack(8'h40, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00), '0);
    check("R10 no normalising", int'(alarm_flag[0]), 0);
    tick_at(pack(8'h3A, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00), '0);
    check("R10 raw match", int'(alarm_flag[0]), 1);
    clear_all();

    // R5: disarm every field of both slots
    wr(0, 0, 8'h3A, 1'b0);
    wr(1, 1, 8'h15, 1'b0);
    wr(1, 5, 8'h01, 1'b0);
    tick_at(pack(8'h3A, 8'h15, 8'h00, 8'h00, 8'h00, 8'h01), '0);
    check("R5 disarmed", int'(alarm_flag), 0);
    check("R5 irq idle", int'(irq_n), 1);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule